// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Start Hold-Off

This block is a software-serviced watchdog. It runs off a one-cycle tick strobe at the 32.768 kHz reference rate and raises an output pulse if software fails to service it within the selected period. A single 8-bit control register configures it. The fields are enable, sticky expiry flag, hold-off enable, pulse-length select, one spare bit and a 3-bit period code. Software services the watchdog with a one-cycle kick, or with any write to the register. After an expiry the watchdog stays stopped until software writes the flag back to zero.

When the hold-off bit is set, an enabling write first waits 64 seconds' worth of ticks before the period count begins. Neither kicks nor further writes shorten or restart that wait. A supply-present input stands for the main rail. When it drops, the enable bit is forced low, and it stays low until software sets it again. For simulation the parameter `SCALE_SHIFT` divides every tick count by a power of two, with a floor of one tick.

Top module: `wdog_core`

## Requirements
- R1: After reset `rd_data` is 0x00 and `wdt_out` is low. A write stores all 8 bits, and `rd_data` returns them from the next cycle. The field layout is bit 7 enable, bit 6 expiry flag, bit 5 hold-off enable, bit 4 pulse-length select, bit 3 spare, and bits 2:0 the period code.
- R2: With hold-off clear, an enabling write that also clears the flag at clock edge w makes expiry happen at edge w+P, with ticks present on every cycle. P is the tick count for the code, scaled by 2^SCALE_SHIFT with a minimum of 1. The tick counts are: code 0 = 32, code 1 = 512, code 2 = 2048, code 3 = 4096, code 4 = 32768, code 5 = 524288, code 6 = 1048576, code 7 = 2097152.
- R3: Bit 3 is stored and read back, and it has no effect on the period.
- R4: On expiry the flag bit becomes 1 and `wdt_out` rises in the same cycle. After that, no further expiry occurs and the flag stays set until a write clears it. A write with enable 1 and flag 0 restarts a full period.
- R5: `wdt_out` stays high for a fixed number of ticks, with the same scaling as R2. It is 4 ticks when bit 4 is 0 and 4096 ticks when bit 4 is 1.
- R6: With hold-off set, counting starts only after 2097152 scaled ticks from the enabling write. Expiry then comes P ticks later. A kick during the hold-off has no effect.
- R7: While `pwr_ok` is low, the enable bit reads 0, even when a write sets it. It stays 0 after `pwr_ok` returns, until software writes it to 1. Counting then restarts from zero.
- R8: Clearing the enable bit stops the watchdog, and no expiry follows.
- R9: While counting, a kick or a write reloads the count to zero. A kick is ignored while the watchdog is disabled or flagged. A kick or write in the same cycle as the final tick wins: no expiry happens, and a full period starts again.
- R10: Only cycles with `tick` high advance the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Value to write to the control register |
| kick | input | 1 | One-cycle service strobe |
| pwr_ok | input | 1 | High while main supply is present |
| rd_data | output | 8 | Current control register contents |
| wdt_out | output | 1 | Active-high watchdog pulse |

## Verification
The critical collision is a service event that lands on the same edge as the final tick of the period. Two functions then compete: the reload and the expiry with its flag set. The bench provokes this by issuing a kick, and separately a write, exactly P-1 cycles after an enabling write, with the tick held high. It judges the result by the cycle in which `wdt_out` first rises. That should be 2P cycles after the original write, not P. The bench also confirms that the hold-off ignores a kick by checking that the expiry falls exactly at hold-off plus period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned BASE_W = 22;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } wdog_state_e;

    // Register layout; field order is the bit order seen by software.
    typedef struct packed {
        logic       en;
        logic       flag;
        logic       dly;
        logic       plong;
        logic       rsvd;
        logic [2:0] code;
    } wdog_ctrl_t;

    localparam logic [BASE_W-1:0] HOLD_BASE  = BASE_W'(2097152);
    localparam logic [BASE_W-1:0] SHORT_BASE = BASE_W'(4);
    localparam logic [BASE_W-1:0] LONG_BASE  = BASE_W'(4096);

    function automatic logic [BASE_W-1:0] period_base(input logic [2:0] code);
        logic [BASE_W-1:0] r;
        case (code)
            3'd0:    r = BASE_W'(32);
            3'd1:    r = BASE_W'(512);
            3'd2:    r = BASE_W'(2048);
            3'd3:    r = BASE_W'(4096);
            3'd4:    r = BASE_W'(32768);
            3'd5:    r = BASE_W'(524288);
            3'd6:    r = BASE_W'(1048576);
            default: r = BASE_W'(2097152);
        endcase
        return r;
    endfunction

    function automatic logic [BASE_W-1:0] scale_ticks(input logic [BASE_W-1:0] base,
                                                       input int unsigned shift);
        logic [BASE_W-1:0] v;
        v = base >> shift;
        return (v == '0) ? BASE_W'(1) : v;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       pwr_ok,
    input  logic       expire,
    output wdog_ctrl_t ctrl_q,
    output wdog_ctrl_t ctrl_d
);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wdog_ctrl_t'(wr_data);
        end else if (expire) begin
            ctrl_d.flag = 1'b1;
        end
        if (!pwr_ok) begin
            ctrl_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    a_r7_supply_loss_clears_enable: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !ctrl_q.en);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !wr_en) |=> ctrl_q.flag);

    a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl_q.flag);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pwr_ok) |=> (ctrl_q == wdog_ctrl_t'($past(wr_data))));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        kick,
    input  logic        wr_en,
    input  wdog_ctrl_t  ctrl_q,
    input  wdog_ctrl_t  ctrl_d,
    output logic        expire,
    output wdog_state_e state_q
);

    localparam int unsigned CNT_W = BASE_W;
    localparam logic [CNT_W-1:0] HOLD_M1 = scale_ticks(HOLD_BASE, SCALE_SHIFT) - BASE_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] period_m1;
    wdog_state_e      state_d;
    logic             go;
    logic             run_end;

    assign period_m1 = scale_ticks(period_base(ctrl_q.code), SCALE_SHIFT) - BASE_W'(1);
    assign go        = ctrl_d.en && !ctrl_d.flag;
    assign run_end   = (state_q == ST_RUN) && tick && (cnt_q == period_m1);
    // A service event on the final tick takes priority over expiry.
    assign expire    = run_end && !kick && !wr_en;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!go) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (wr_en) begin
            case (state_q)
                ST_IDLE: begin
                    state_d = ctrl_d.dly ? ST_HOLD : ST_RUN;
                    cnt_d   = '0;
                end
                ST_RUN:  cnt_d = '0;
                default: ;
            endcase
        end else begin
            case (state_q)
                ST_HOLD: begin
                    if (tick) begin
                        if (cnt_q == HOLD_M1) begin
                            state_d = ST_RUN;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (kick) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    a_r4_stopped_while_flagged: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.flag |-> (state_q == ST_IDLE));

    a_r8_disabled_is_idle: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> (state_q == ST_IDLE));

    a_r6_hold_ignores_kick: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_HOLD) && kick && !tick && !wr_en && ctrl_d.en)
            |=> ((state_q == ST_HOLD) && $stable(cnt_q)));

    a_r9_kick_reloads: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RUN) && kick && !wr_en && ctrl_d.en) |=> (cnt_q == '0));

    a_r10_no_tick_no_advance: assert property (@(posedge clk) disable iff (rst)
        (!tick && !kick && !wr_en && (state_q != ST_IDLE) && ctrl_d.en) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    input  logic plong,
    output logic out
);

    localparam int unsigned PW_W = $clog2(int'(LONG_BASE)) + 1;
    localparam logic [PW_W-1:0] SHORT_M1 = PW_W'(scale_ticks(SHORT_BASE, SCALE_SHIFT) - BASE_W'(1));
    localparam logic [PW_W-1:0] LONG_M1  = PW_W'(scale_ticks(LONG_BASE, SCALE_SHIFT) - BASE_W'(1));

    logic [PW_W-1:0] cnt_q;
    logic [PW_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out    <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (fire) begin
            out    <= 1'b1;
            cnt_q  <= '0;
            last_q <= plong ? LONG_M1 : SHORT_M1;
        end else if (out && tick) begin
            if (cnt_q == last_q) begin
                out <= 1'b0;
            end else begin
                cnt_q <= cnt_q + PW_W'(1);
            end
        end
    end

    a_r5_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(out) |-> $past(fire));

    a_r5_fire_drives_out: assert property (@(posedge clk) disable iff (rst)
        fire |=> out);

    a_r10_pulse_holds_without_tick: assert property (@(posedge clk) disable iff (rst)
        (out && !tick && !fire) |=> out);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       kick,
    input  logic       pwr_ok,
    output logic [7:0] rd_data,
    output logic       wdt_out
);

    wdog_ctrl_t  ctrl_q;
    wdog_ctrl_t  ctrl_d;
    logic        expire;
    wdog_state_e state_q;

    wdog_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pwr_ok  (pwr_ok),
        .expire  (expire),
        .ctrl_q  (ctrl_q),
        .ctrl_d  (ctrl_d)
    );

    wdog_timer #(.SCALE_SHIFT(SCALE_SHIFT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .kick    (kick),
        .wr_en   (wr_en),
        .ctrl_q  (ctrl_q),
        .ctrl_d  (ctrl_d),
        .expire  (expire),
        .state_q (state_q)
    );

    wdog_pulse #(.SCALE_SHIFT(SCALE_SHIFT)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .fire  (expire),
        .plong (ctrl_q.plong),
        .out   (wdt_out)
    );

    assign rd_data = ctrl_q;

    a_r4_out_rises_with_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_out) |-> ctrl_q.flag);

    a_r6_no_expiry_in_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> !expire);

endmodule

// File: tb/tb_wdog_core.sv
`timescale 1ns/1ps
module tb_wdog_core;

    localparam int SH  = 6;
    localparam int LIM = 70000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic       pwr_ok = 1'b1;
    logic [7:0] rd_data;
    logic       wdt_out;

    int checks = 0;
    int fails  = 0;

    wdog_core #(.SCALE_SHIFT(SH)) dut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .kick    (kick),
        .pwr_ok  (pwr_ok),
        .rd_data (rd_data),
        .wdt_out (wdt_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scaled(input int base);
        int v;
        v = base >> SH;
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int per(input int code);
        int b;
        b = 32 << (4 * (code & 1));
        case (code & 7)
            0: b = 32;
            1: b = 512;
            2: b = 2048;
            3: b = 4096;
            4: b = 32768;
            5: b = 32768 * 16;
            6: b = 32768 * 32;
            default: b = 32768 * 64;
        endcase
        return scaled(b);
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic measure(input int kick_at, output int n);
        n = 0;
        while (!wdt_out && n < LIM) begin
            @(negedge clk);
            n++;
            kick = (n == kick_at);
        end
        kick = 1'b0;
    endtask

    task automatic pulse_len(output int m);
        m = 0;
        while (wdt_out && m < LIM) begin
            @(negedge clk);
            m++;
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(5.0 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int n, m;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1 reset rd_data", rd_data, 0);
        chk("R1 reset wdt_out", wdt_out, 0);

        // R1 readback, disabled so R8 nothing happens
        wr(8'h2B);
        chk("R1 readback", rd_data, 8'h2B);
        idle(100);
        chk("R8 disabled no pulse", wdt_out, 0);

        // R2 / R4 / R5 sweep over every period code
        for (int c = 0; c < 8; c++) begin
            logic sel;
            sel = logic'(c & 1);
            wr({1'b1, 1'b0, 1'b0, sel, 1'b0, 3'(c)});
            measure(-1, n);
            chk($sformatf("R2 period code %0d", c), n, per(c));
            chk("R4 flag set on expiry", rd_data[6], 1);
            pulse_len(m);
            chk($sformatf("R5 pulse len sel %0d", sel), m, sel ? scaled(4096) : scaled(4));
            idle(20);
            chk("R4 stays stopped", wdt_out, 0);
            chk("R4 flag sticky", rd_data[6], 1);
        end

        // R3 spare bit does not change period
        for (int c = 0; c < 4; c++) begin
            wr(8'h88 | 8'(c));
            chk("R3 spare bit readback", rd_data, 8'h88 | c);
            measure(-1, n);
            chk($sformatf("R3 period code %0d with spare", c), n, per(c));
            pulse_len(m);
        end

        // R9 kick while flagged is ignored
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        idle(50);
        chk("R9 kick while flagged out", wdt_out, 0);
        chk("R9 kick while flagged flag", rd_data[6], 1);

        // R9 kick mid-period reloads
        wr(8'h82);
        measure(10, n);
        chk("R9 kick reload", n, 11 + per(2));
        pulse_len(m);

        // R9 kick on final tick wins
        wr(8'h82);
        measure(per(2) - 1, n);
        chk("R9 kick on final tick", n, 2 * per(2));
        pulse_len(m);

        // R9 write on final tick wins
        wr(8'h82);
        idle(per(2) - 2);
        wr(8'h82);
        measure(-1, n);
        chk("R9 write on final tick", n, per(2));
        pulse_len(m);

        // R6 hold-off, kick during hold ignored
        wr(8'hA1);
        measure(100, n);
        chk("R6 hold-off then period", n, scaled(2097152) + per(1));
        pulse_len(m);

        // R7 supply loss
        wr(8'h83);
        idle(10);
        pwr_ok = 1'b0;
        idle(5);
        pwr_ok = 1'b1;
        idle(1);
        chk("R7 enable cleared", rd_data[7], 0);
        idle(200);
        chk("R7 no expiry after loss", wdt_out, 0);
        pwr_ok = 1'b0;
        wr(8'h81);
        chk("R7 enable blocked while low", rd_data[7], 0);
        pwr_ok = 1'b1;
        idle(20);
        chk("R7 stays disabled on return", rd_data[7], 0);
        wr(8'h81);
        measure(-1, n);
        chk("R7 restart after software enable", n, per(1));
        pulse_len(m);

        // R8 clearing enable stops the watchdog
        wr(8'h82);
        idle(5);
        wr(8'h02);
        idle(100);
        chk("R8 stopped out", wdt_out, 0);
        chk("R8 stopped reg", rd_data, 8'h02);

        // R10 no tick, no progress
        tick = 1'b0;
        wr(8'h81);
        idle(500);
        chk("R10 no expiry without tick", wdt_out, 0);
        chk("R10 flag clear without tick", rd_data[6], 0);
        tick = 1'b1;
        measure(-1, n);
        chk("R10 counts once tick resumes", n, per(1));
        pulse_len(m);

        summary();
        $finish;
    end

endmodule